// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

This block is an eight-pin general-purpose I/O port that a processor controls through a small register bus. Each pin has a direction bit and an output latch bit. A pin whose direction bit is 0 drives its latch value. A pin whose direction bit is 1 is an input, and its driver is released. Software reads two different views of the port. The pin view returns the pin levels after synchronization. The latch view returns what software last stored.

Single-bit set, clear and toggle commands modify the latch in one cycle. They always start from the latch value and never from the sampled pins. This keeps the result correct while some pins are inputs, or while pins are loaded externally. Weak pull-ups can be enabled for all pins with one global bit, which is active low. A pull-up is withheld from every pin that is currently driving. A per-pin override input lets a peripheral take over the pin's enable and value.

The register bus has a 3-bit address, a one-cycle write strobe, write data and a combinational read path. Register selects are: 0 direction, 1 latch, 2 pin view, 3 config (bit 0 is the active-low pull-up enable), 4 bit command. There is no multi-state sequencing in this block. Each register update is a single-cycle transition from its present value to the next value chosen by the decoded write.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register reads 0xFF, the latch reads 0x00 and config reads 0x01. With no override, pin_oe is 0x00 and pin_pu is 0x00.
- R2: With no override, pin_oe[i] is the inverse of direction bit i, starting the cycle after a write to address 0. pin_out carries the latch.
- R3: A write to address 1 or address 2 loads the whole latch, effective the next cycle. Reading address 1 returns the latch contents.
- R4: Reading address 2 returns pin_in delayed by two clock edges. The value is independent of the latch and of direction.
- R5: A write to address 4 takes the bit index from wdata[2:0] and the opcode from wdata[4:3]. Opcode 01 sets the latch bit, 10 clears it and 11 inverts it. Opcode 00 changes nothing. Other latch bits are unchanged.
- R6: Bit commands start from the stored latch, not from the pin levels. The pins change only where the direction bit is 0.
- R7: When config bit 0 is 0, pin_pu[i] is 1 for every pin that is not driving. When config bit 0 is 1, pin_pu is all zeros. A driving pin never has its pull-up on.
- R8: Where ovr_en[i] is 1, pin_oe[i] equals ovr_oe[i] and pin_out[i] equals ovr_val[i], regardless of the registers.
- R9: Reading address 3 returns {7'b0, pull-up-disable bit}. Reading address 4 or any unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Value driven onto each pin |
| pin_oe | output | 8 | Per-pin driver enable |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| ovr_en | input | 8 | Per-pin peripheral override select |
| ovr_oe | input | 8 | Override driver enable |
| ovr_val | input | 8 | Override drive value |

## Verification
The bench tries all 256 direction values, once with pull-ups enabled and once with them disabled. This shows that enable inversion and pull-up gating are correct bit by bit.

All 256 pin patterns are read through the pin view, with the latch held at a different value. This separates the pin path from the latch path, and a check between the two edges confirms the two-edge delay.

Every index is run with every opcode, including the no-op, starting from an asymmetric latch value. A toggle is also issued while the pins hold the complement of the latch. This catches a command that works on the wrong bit, or one that starts from the pins instead of the latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [2:0] {
        REG_DIR = 3'd0,
        REG_LAT = 3'd1,
        REG_PIN = 3'd2,
        REG_CFG = 3'd3,
        REG_BIT = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        BOP_NONE = 2'b00,
        BOP_SET  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_TGL  = 2'b11
    } bit_op_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_latch_next.sv
module gpio_latch_next
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] lat_q,
    input  logic             load_full,
    input  logic [WIDTH-1:0] full_val,
    input  logic             load_bit,
    input  logic [IDX_W-1:0] bit_idx,
    input  bit_op_e          bit_op,
    output logic [WIDTH-1:0] lat_d
);
    logic [WIDTH-1:0] sel_mask;

    always_comb begin
        sel_mask = '0;
        sel_mask[bit_idx] = 1'b1;
        lat_d = lat_q;
        if (load_full) begin
            lat_d = full_val;
        end else if (load_bit) begin
            unique case (bit_op)
                BOP_NONE: lat_d = lat_q;
                BOP_SET:  lat_d = lat_q | sel_mask;
                BOP_CLR:  lat_d = lat_q & ~sel_mask;
                BOP_TGL:  lat_d = lat_q ^ sel_mask;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] lat,
    input  logic             pu_dis,
    input  logic [WIDTH-1:0] ovr_en,
    input  logic [WIDTH-1:0] ovr_oe,
    input  logic [WIDTH-1:0] ovr_val,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pad
        always_comb begin
            if (ovr_en[i]) begin
                pin_oe[i]  = ovr_oe[i];
                pin_out[i] = ovr_val[i];
            end else begin
                pin_oe[i]  = ~dir[i];
                pin_out[i] = lat[i];
            end
            pin_pu[i] = ~pu_dis & ~pin_oe[i];
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 3,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_pu,
    input  logic [WIDTH-1:0]  ovr_en,
    input  logic [WIDTH-1:0]  ovr_oe,
    input  logic [WIDTH-1:0]  ovr_val
);
    logic [WIDTH-1:0] dir_q, lat_q, lat_d, pin_sync;
    logic             pu_dis_q;
    logic             wr_dir, wr_full, wr_bit, wr_cfg;
    bit_op_e          op;

    assign wr_dir  = wr_en && (addr == ADDR_W'(REG_DIR));
    assign wr_full = wr_en && ((addr == ADDR_W'(REG_LAT)) || (addr == ADDR_W'(REG_PIN)));
    assign wr_bit  = wr_en && (addr == ADDR_W'(REG_BIT));
    assign wr_cfg  = wr_en && (addr == ADDR_W'(REG_CFG));
    assign op      = bit_op_e'(wdata[IDX_W+1:IDX_W]);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_latch_next #(.WIDTH(WIDTH)) u_next (
        .lat_q(lat_q), .load_full(wr_full), .full_val(wdata),
        .load_bit(wr_bit), .bit_idx(wdata[IDX_W-1:0]), .bit_op(op),
        .lat_d(lat_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '1;
            lat_q    <= '0;
            pu_dis_q <= 1'b1;
        end else begin
            if (wr_dir) dir_q <= wdata;
            if (wr_cfg) pu_dis_q <= wdata[0];
            lat_q <= lat_d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(REG_DIR): rdata = dir_q;
            ADDR_W'(REG_LAT): rdata = lat_q;
            ADDR_W'(REG_PIN): rdata = pin_sync;
            ADDR_W'(REG_CFG): rdata = {{(WIDTH-1){1'b0}}, pu_dis_q};
            default:          rdata = '0;
        endcase
    end

    gpio_pad_mux #(.WIDTH(WIDTH)) u_pad (
        .dir(dir_q), .lat(lat_q), .pu_dis(pu_dis_q),
        .ovr_en(ovr_en), .ovr_oe(ovr_oe), .ovr_val(ovr_val),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [WIDTH-1:0]  wdata,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_pu,
    input logic [WIDTH-1:0]  ovr_en
);
    // R2: a direction write shows up inverted on the enables of non-overridden pins
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_DIR)) |=>
        ((pin_oe & ~ovr_en) == (~$past(wdata) & ~ovr_en)));

    // R3: a full latch write shows up on the outputs of non-overridden pins
    a_r3_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(REG_LAT) || addr == ADDR_W'(REG_PIN))) |=>
        ((pin_out & ~ovr_en) == ($past(wdata) & ~ovr_en)));

    // R5: a bit command changes at most one latch-driven output bit
    a_r5_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(REG_BIT)) |=>
        ($countones((pin_out ^ $past(pin_out)) & ~ovr_en & ~$past(ovr_en)) <= 1));

    // R7: no pin is pulled up while it drives
    a_r7_pu_off_when_driving: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pu & pin_oe) == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .ovr_en(ovr_en)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe, pin_pu;
    logic [7:0] ovr_en = '0, ovr_oe = '0, ovr_val = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] m_dir, m_lat;
    logic       m_pudis;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pu(pin_pu), .ovr_en(ovr_en), .ovr_oe(ovr_oe), .ovr_val(ovr_val)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [7:0] exp_oe();
        return (~m_dir & ~ovr_en) | (ovr_oe & ovr_en);
    endfunction

    function automatic logic [7:0] exp_out();
        return (m_lat & ~ovr_en) | (ovr_val & ovr_en);
    endfunction

    function automatic logic [7:0] exp_pu();
        return m_pudis ? 8'h00 : ~exp_oe();
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        m_dir = 8'hFF; m_lat = 8'h00; m_pudis = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        rd(3'd0, v); check("R1 dir", v, 8'hFF);
        rd(3'd1, v); check("R1 lat", v, 8'h00);
        rd(3'd3, v); check("R1 cfg", v, 8'h01);
        check("R1 oe", pin_oe, 8'h00);
        check("R1 pu", pin_pu, 8'h00);

        // R2 and R7: sweep of every direction value, pull-ups off then on
        wr(3'd1, 8'h5A); m_lat = 8'h5A;
        for (int p = 0; p < 2; p++) begin
            m_pudis = (p == 0);
            wr(3'd3, {7'b0, m_pudis});
            for (int d = 0; d < 256; d++) begin
                wr(3'd0, 8'(d)); m_dir = 8'(d);
                check("R2 oe", pin_oe, exp_oe());
                check("R7 pu", pin_pu, exp_pu());
            end
        end
        check("R2 out", pin_out, exp_out());

        // R3 full writes through both addresses, latch readback
        wr(3'd1, 8'hC3); m_lat = 8'hC3;
        rd(3'd1, v); check("R3 lat via addr1", v, 8'hC3);
        check("R3 out", pin_out, 8'hC3);
        wr(3'd2, 8'h3C); m_lat = 8'h3C;
        rd(3'd1, v); check("R3 lat via addr2", v, 8'h3C);

        // R4 pin view: delay of two edges, independent of the latch
        wr(3'd0, 8'hFF); m_dir = 8'hFF;
        @(negedge clk); pin_in = 8'h00;
        repeat (2) @(negedge clk);
        @(negedge clk); pin_in = 8'h96; addr = 3'd2;
        @(negedge clk); #1; check("R4 one edge", rdata, 8'h00);
        @(negedge clk); #1; check("R4 two edges", rdata, 8'h96);
        rd(3'd1, v); check("R4 latch unaffected", v, 8'h3C);
        for (int x = 0; x < 256; x++) begin
            @(negedge clk); pin_in = 8'(x); addr = 3'd2;
            repeat (2) @(negedge clk);
            #1; check("R4 sweep", rdata, 8'(x));
        end

        // R5 every index with every opcode
        wr(3'd0, 8'h00); m_dir = 8'h00;
        wr(3'd1, 8'hA5); m_lat = 8'hA5;
        for (int i = 0; i < 8; i++) begin
            for (int o = 0; o < 4; o++) begin
                wr(3'd4, {3'b000, 2'(o), 3'(i)});
                case (o)
                    1: m_lat[i] = 1'b1;
                    2: m_lat[i] = 1'b0;
                    3: m_lat[i] = ~m_lat[i];
                    default: ;
                endcase
                rd(3'd1, v); check("R5 bitop lat", v, m_lat);
                check("R5 bitop out", pin_out, m_lat);
            end
        end

        // R6 bit command starts from the latch while pins disagree
        wr(3'd1, 8'h0F); m_lat = 8'h0F;
        wr(3'd0, 8'hF0); m_dir = 8'hF0;
        @(negedge clk); pin_in = 8'hF0;
        repeat (3) @(negedge clk);
        wr(3'd4, {3'b000, 2'b11, 3'd1}); m_lat[1] = 1'b0;
        rd(3'd1, v); check("R6 toggle from latch", v, 8'h0D);
        wr(3'd4, {3'b000, 2'b01, 3'd6}); m_lat[6] = 1'b1;
        rd(3'd1, v); check("R6 set on input pin", v, 8'h4D);
        check("R6 oe only outputs", pin_oe, 8'h0F);
        rd(3'd2, v); check("R6 pins unchanged", v, 8'hF0);

        // R8 override
        wr(3'd3, 8'h00); m_pudis = 1'b0;
        @(negedge clk); ovr_en = 8'h0F; ovr_oe = 8'h05; ovr_val = 8'h03;
        #1;
        check("R8 oe", pin_oe, exp_oe());
        check("R8 out", pin_out, exp_out());
        check("R8 pu", pin_pu, exp_pu());
        @(negedge clk); ovr_en = 8'hF0; ovr_oe = 8'h00; ovr_val = 8'hFF;
        #1;
        check("R8 oe upper", pin_oe, exp_oe());
        check("R8 out upper", pin_out, exp_out());
        @(negedge clk); ovr_en = 8'h00;

        // R9 config and unmapped reads
        rd(3'd3, v); check("R9 cfg", v, 8'h00);
        wr(3'd3, 8'hFF); m_pudis = 1'b1;
        rd(3'd3, v); check("R9 cfg upper zero", v, 8'h01);
        rd(3'd4, v); check("R9 bitcmd read", v, 8'h00);
        rd(3'd5, v); check("R9 unmapped 5", v, 8'h00);
        rd(3'd7, v); check("R9 unmapped 7", v, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule